// File: doc/BRIEF.md
# Word Memory with Low-Address I/O Window

This block is a 4096-word by 16-bit synchronous memory addressed by 12 bits, in which the eight lowest addresses do not reach RAM. The eight words at 0x000..0x007 are I/O ports instead. Address 0x000 reads an external 8-bit switch bank. Addresses 0x001, 0x002 and 0x003 hold registered outputs: an 8-bit LED bank, a 4-bit digit-select (anode) field and an 8-bit segment (cathode) field. The remaining four port addresses are unused. Every address from 0x008 upward is ordinary RAM. The span 0x008..0x07F is the data region (120 words) and 0x080..0xFFF is the program region (3968 words). Both regions behave the same.

A processor drives a read strobe, a write strobe, an address and write data. Writes take effect on the rising clock edge. Read data is registered and appears one cycle after the read strobe. Port values are zero-extended to the full word on reads, and a write to a port keeps only the port's low bits.

Top module: `iomap_mem`

## Requirements
- R1: While `rst_n` is low, `led`, `anode`, `cathode` and `rd_data` are all zero. The reset is asynchronous.
- R2: A write to address 0x001 with `wr_en` high loads `wr_data[7:0]` into `led` at that clock edge. The upper bits are discarded.
- R3: A write to address 0x002 loads `wr_data[3:0]` into `anode`.
- R4: A write to address 0x003 loads `wr_data[7:0]` into `cathode`.
- R5: A read of address 0x000 returns `{8'h00, sw}`, with `sw` sampled at the edge where `rd_en` is high.
- R6: A read of 0x001, 0x002 or 0x003 returns that port's current register contents, zero-extended. A read of 0x004..0x007 returns zero.
- R7: A write to 0x000 or to 0x004..0x007 changes no output port. A port output changes only through a write to its own address.
- R8: Every address from 0x008 to 0xFFF stores a full 16-bit word. A later read returns the last value written, including at the region edges 0x008, 0x07F, 0x080 and 0xFFF.
- R9: `rd_data` is registered. It changes only after an edge where `rd_en` was high, and holds its value otherwise.
- R10: When `rd_en` and `wr_en` are both high for the same address, the read returns the contents from before that write. This holds for RAM and for output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| sw | input | 8 | External switch inputs |
| led | output | 8 | LED port register |
| anode | output | 4 | Digit-select port register |
| cathode | output | 8 | Segment port register |

## Verification
The vectors write values whose upper bits are set to the three output ports. Reading those ports back shows whether the upper bits are truncated and the result zero-extended, instead of being stored whole. Distinct words are written to both edges of the data region and both edges of the program region. The read-back then tells a correct region decode apart from an off-by-one boundary or aliasing. Writes to the switch address and to an unused port, each followed by reads of the LED port and the spare port, separate ignored writes from writes that leak into another port. Combined read-and-write cycles on a RAM word and on the LED port tell read-before-write order apart from write-through.

// File: rtl/iomap_pkg.sv
package iomap_pkg;

  typedef enum logic [2:0] {
    RG_SWITCH,
    RG_LED,
    RG_ANODE,
    RG_CATHODE,
    RG_SPARE,
    RG_DATA,
    RG_PROG
  } region_e;

  typedef struct packed {
    logic sw;
    logic led;
    logic anode;
    logic cath;
    logic spare;
    logic ram;
  } sel_t;

  // Map a word address to its region. The port offsets are fixed by behaviour.
  function automatic region_e classify(input int unsigned a,
                                       input int unsigned io_words,
                                       input int unsigned data_end);
    if (a >= io_words) begin
      if (a <= data_end) return RG_DATA;
      return RG_PROG;
    end
    case (a)
      0:       return RG_SWITCH;
      1:       return RG_LED;
      2:       return RG_ANODE;
      3:       return RG_CATHODE;
      default: return RG_SPARE;
    endcase
  endfunction

endpackage

// File: rtl/iomap_decode.sv
module iomap_decode
  import iomap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IO_WORDS = 8,
  parameter int unsigned DATA_END = 32'h07F
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);

  region_e region;

  always_comb begin
    region    = classify(32'(addr), IO_WORDS, DATA_END);
    sel       = '0;
    sel.sw    = (region == RG_SWITCH);
    sel.led   = (region == RG_LED);
    sel.anode = (region == RG_ANODE);
    sel.cath  = (region == RG_CATHODE);
    sel.spare = (region == RG_SPARE);
    sel.ram   = (region == RG_DATA) || (region == RG_PROG);
  end

endmodule

// File: rtl/iomap_ports.sv
module iomap_ports #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IN_W   = 8,
  parameter int unsigned SW_W   = 8,
  parameter int unsigned LED_W  = 8,
  parameter int unsigned AN_W   = 4,
  parameter int unsigned CATH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_sw,
  input  logic              sel_led,
  input  logic              sel_an,
  input  logic              sel_cath,
  input  logic [IN_W-1:0]   wr_lo,
  input  logic [SW_W-1:0]   sw,
  output logic [LED_W-1:0]  led,
  output logic [AN_W-1:0]   anode,
  output logic [CATH_W-1:0] cathode,
  output logic [DATA_W-1:0] rd_value
);

  logic ld_led, ld_an, ld_cath;

  assign ld_led  = wr_en && sel_led;
  assign ld_an   = wr_en && sel_an;
  assign ld_cath = wr_en && sel_cath;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led     <= '0;
      anode   <= '0;
      cathode <= '0;
    end else begin
      if (ld_led)  led     <= wr_lo[LED_W-1:0];
      if (ld_an)   anode   <= wr_lo[AN_W-1:0];
      if (ld_cath) cathode <= wr_lo[CATH_W-1:0];
    end
  end

  // Current port contents, zero-extended; spare ports and RAM give zero here.
  always_comb begin
    rd_value = '0;
    if (sel_sw)   rd_value = DATA_W'(sw);
    if (sel_led)  rd_value = DATA_W'(led);
    if (sel_an)   rd_value = DATA_W'(anode);
    if (sel_cath) rd_value = DATA_W'(cathode);
  end

  AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_led |=> led == $past(wr_lo[LED_W-1:0])); // R2
  AST_AN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_an |=> anode == $past(wr_lo[AN_W-1:0])); // R3
  AST_CATH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cath |=> cathode == $past(wr_lo[CATH_W-1:0])); // R4
  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_led |=> $stable(led)); // R7
  AST_AN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_an |=> $stable(anode)); // R7
  AST_CATH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cath |=> $stable(cathode)); // R7
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (led == '0 && anode == '0 && cathode == '0)); // R1

endmodule

// File: rtl/iomap_ram.sv
module iomap_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Nonblocking update gives read-before-write on a shared address.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end

endmodule

// File: rtl/iomap_mem.sv
module iomap_mem
  import iomap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IO_WORDS = 8,
  parameter int unsigned DATA_END = 32'h07F,
  parameter int unsigned SW_W     = 8,
  parameter int unsigned LED_W    = 8,
  parameter int unsigned AN_W     = 4,
  parameter int unsigned CATH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SW_W-1:0]   sw,
  output logic [LED_W-1:0]  led,
  output logic [AN_W-1:0]   anode,
  output logic [CATH_W-1:0] cathode
);

  localparam int unsigned W01  = (LED_W > AN_W) ? LED_W : AN_W;
  localparam int unsigned IN_W = (W01 > CATH_W) ? W01 : CATH_W;

  sel_t              sel_w;
  logic [DATA_W-1:0] io_val;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] io_q;
  logic              from_ram;
  logic              ram_we;

  iomap_decode #(
    .ADDR_W  (ADDR_W),
    .IO_WORDS(IO_WORDS),
    .DATA_END(DATA_END)
  ) u_decode (
    .addr(addr),
    .sel (sel_w)
  );

  iomap_ports #(
    .DATA_W(DATA_W),
    .IN_W  (IN_W),
    .SW_W  (SW_W),
    .LED_W (LED_W),
    .AN_W  (AN_W),
    .CATH_W(CATH_W)
  ) u_ports (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .sel_sw  (sel_w.sw),
    .sel_led (sel_w.led),
    .sel_an  (sel_w.anode),
    .sel_cath(sel_w.cath),
    .wr_lo   (wr_data[IN_W-1:0]),
    .sw      (sw),
    .led     (led),
    .anode   (anode),
    .cathode (cathode),
    .rd_value(io_val)
  );

  assign ram_we = wr_en && sel_w.ram;

  iomap_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (rd_en),
    .addr (addr),
    .wdata(wr_data),
    .rdata(ram_q)
  );

  // Port reads are registered here; the RAM word is registered inside the RAM.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q     <= '0;
      from_ram <= 1'b0;
    end else if (rd_en) begin
      io_q     <= io_val;
      from_ram <= sel_w.ram;
    end
  end

  assign rd_data = from_ram ? ram_q : io_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_w) == 1); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R9
  AST_SW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_w.sw) |=> rd_data == DATA_W'($past(sw))); // R5
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_w.spare) |=> rd_data == '0); // R6
  AST_LED_RBW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_w.led) |=> rd_data == DATA_W'($past(led))); // R10

endmodule

// File: tb/iomap_mem_tb.sv
`timescale 1ns/1ps
module iomap_mem_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [7:0]  sw = '0;
  logic [7:0]  led;
  logic [3:0]  anode;
  logic [7:0]  cathode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  iomap_mem u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .sw(sw), .led(led),
    .anode(anode), .cathode(cathode)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] a;
    logic [15:0] d;
    logic [7:0]  s;
    logic        chk;
    logic [3:0]  req;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 12'h001, 16'hABCD, 8'h00, 1'b0, 4'd2,  16'h0000},
    '{1'b0, 1'b1, 12'h001, 16'h0000, 8'h00, 1'b1, 4'd2,  16'h00CD}, // R2 truncation
    '{1'b1, 1'b0, 12'h002, 16'hFFF5, 8'h00, 1'b0, 4'd3,  16'h0000},
    '{1'b0, 1'b1, 12'h002, 16'h0000, 8'h00, 1'b1, 4'd3,  16'h0005}, // R3
    '{1'b1, 1'b0, 12'h003, 16'h1234, 8'h00, 1'b0, 4'd4,  16'h0000},
    '{1'b0, 1'b1, 12'h003, 16'h0000, 8'h00, 1'b1, 4'd4,  16'h0034}, // R4
    '{1'b0, 1'b1, 12'h000, 16'h0000, 8'hA5, 1'b1, 4'd5,  16'h00A5}, // R5
    '{1'b0, 1'b1, 12'h000, 16'h0000, 8'h3C, 1'b1, 4'd5,  16'h003C}, // R5
    '{1'b1, 1'b0, 12'h008, 16'h1111, 8'h00, 1'b0, 4'd8,  16'h0000},
    '{1'b1, 1'b0, 12'h07F, 16'h2222, 8'h00, 1'b0, 4'd8,  16'h0000},
    '{1'b1, 1'b0, 12'h080, 16'h3333, 8'h00, 1'b0, 4'd8,  16'h0000},
    '{1'b1, 1'b0, 12'hFFF, 16'h4444, 8'h00, 1'b0, 4'd8,  16'h0000},
    '{1'b0, 1'b1, 12'h008, 16'h0000, 8'h00, 1'b1, 4'd8,  16'h1111}, // R8
    '{1'b0, 1'b1, 12'h07F, 16'h0000, 8'h00, 1'b1, 4'd8,  16'h2222}, // R8
    '{1'b0, 1'b1, 12'h080, 16'h0000, 8'h00, 1'b1, 4'd8,  16'h3333}, // R8
    '{1'b0, 1'b1, 12'hFFF, 16'h0000, 8'h00, 1'b1, 4'd8,  16'h4444}, // R8
    '{1'b1, 1'b0, 12'h005, 16'hBEEF, 8'h00, 1'b0, 4'd7,  16'h0000},
    '{1'b0, 1'b1, 12'h005, 16'h0000, 8'h00, 1'b1, 4'd7,  16'h0000}, // R7
    '{1'b1, 1'b0, 12'h000, 16'h00FF, 8'h11, 1'b0, 4'd7,  16'h0000},
    '{1'b0, 1'b1, 12'h001, 16'h0000, 8'h00, 1'b1, 4'd7,  16'h00CD}, // R7
    '{1'b0, 1'b1, 12'h006, 16'h0000, 8'h00, 1'b1, 4'd6,  16'h0000}, // R6
    '{1'b1, 1'b0, 12'h100, 16'hAAAA, 8'h00, 1'b0, 4'd10, 16'h0000},
    '{1'b1, 1'b1, 12'h100, 16'h5555, 8'h00, 1'b1, 4'd10, 16'hAAAA}, // R10 RAM
    '{1'b0, 1'b1, 12'h100, 16'h0000, 8'h00, 1'b1, 4'd8,  16'h5555}, // R8
    '{1'b1, 1'b1, 12'h001, 16'h0077, 8'h00, 1'b1, 4'd10, 16'h00CD}, // R10 port
    '{1'b0, 1'b1, 12'h001, 16'h0000, 8'h00, 1'b1, 4'd2,  16'h0077}  // R2
  };

  task automatic check(input string tag, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [11:0] a,
                      input logic [15:0] d, input logic [7:0] s);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wr_data = d; sw = s;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 led in reset", 16'(led), 16'h0);
    check("R1 anode in reset", 16'(anode), 16'h0);
    check("R1 cathode in reset", 16'(cathode), 16'h0);
    check("R1 rd_data in reset", rd_data, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].rd, VEC[i].a, VEC[i].d, VEC[i].s);
      if (VEC[i].chk)
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
    end

    // Output pins after the table: R2 R3 R4 (and R7: ignored writes left them)
    step(1'b0, 1'b0, 12'h000, 16'h0, 8'h00);
    check("R2 led pin", 16'(led), 16'h0077);
    check("R3 anode pin", 16'(anode), 16'h0005);
    check("R4 cathode pin", 16'(cathode), 16'h0034);

    // R9: no read strobe, so rd_data holds while address and switches move
    step(1'b0, 1'b0, 12'h000, 16'h0, 8'hFF);
    check("R9 hold on switch addr", rd_data, 16'h0077);
    step(1'b0, 1'b0, 12'h100, 16'h0, 8'h00);
    check("R9 hold on ram addr", rd_data, 16'h0077);

    // R1: asynchronous reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 led async clear", 16'(led), 16'h0);
    check("R1 anode async clear", 16'(anode), 16'h0);
    check("R1 cathode async clear", 16'(cathode), 16'h0);
    check("R1 rd_data async clear", rd_data, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: no write strobe, no load
    step(1'b0, 1'b0, 12'h001, 16'hFFFF, 8'h00);
    check("R2 no load without wr_en", 16'(led), 16'h0);
    // R7: unused port write leaves cathode and anode alone
    step(1'b1, 1'b0, 12'h007, 16'hFFFF, 8'h00);
    check("R7 spare write anode", 16'(anode), 16'h0);
    check("R7 spare write cathode", 16'(cathode), 16'h0);

    step(1'b0, 1'b0, 12'h000, 16'h0, 8'h00);
    finish_run();
  end

endmodule